// File: doc/BRIEF.md
# Variable-Length Instruction Prefix and Operand Decoder

This block takes a window of instruction bytes, together with the current default operand size and address size, and works out the shape of the instruction at the front of the window. It skips the legacy prefix bytes and records what they select: segment override, bus lock, the two repeat forms, and toggles of operand and address size. It then detects the two-byte escape opcode and decodes the ModRM byte, plus the SIB byte where one is present, under either 16-bit or 32-bit addressing. From this it extracts the displacement and the immediate with the correct extension and adds up the total instruction length.

Per-opcode knowledge is not held here. The fetch stage supplies it with each window: whether a ModRM byte follows the opcode, the kind of immediate, whether that immediate is signed, and whether the opcode honours a repeat prefix. A full decode takes one cycle. The result sits in a one-entry output register.

Both ends are valid/ready streams. A window is taken on any rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in that same cycle. A result is offered on `out_valid` from the edge that takes the window onward. It stays unchanged until the edge where `out_ready` is high. The upstream side may hold `in_valid` for as long as it needs; nothing is lost while `in_ready` is low.

Top module: `insn_len_dec`

## Requirements
- R1: `in_ready` is high when `out_valid` is low or `out_ready` is high. A window taken on an edge shows up on the outputs with `out_valid` high right after that edge. While `out_valid` is high and `out_ready` is low, every output holds its value. After reset, `out_valid` is low and `in_ready` is high.
- R2: The prefix bytes 0x26, 0x2E, 0x36, 0x3E, 0x64 and 0x65 set `out_seg` to 1, 2, 3, 4, 5 and 6 respectively. When no segment prefix is present, `out_seg` is 0. When several segment prefixes appear, the last one wins.
- R3: 0xF0 sets `out_lock`. 0xF2 sets `out_rep` bit 0 and 0xF3 sets `out_rep` bit 1; both bits may be set together. If the opcode is not marked repeatable, `out_rep` is 0.
- R4: Any number of 0x66 bytes inverts the default operand size exactly once. Any number of 0x67 bytes inverts the default address size exactly once. The outputs `out_op32` and `out_ad32` carry the resulting sizes (1 = 32-bit).
- R5: When the first byte after the prefixes is 0x0F, the opcode takes two bytes and `out_two_byte` is 1.
- R6: Under 32-bit addressing, with `out_reg` = ModRM bits 5:3, the ModRM mod field (bits 7:6) and rm field (bits 2:0) decode as follows.
  - mod=3: register operand, `out_mem` = 0.
  - mod=0, rm=5: a 4-byte displacement and no base register.
  - mod=1: a 1-byte displacement is added.
  - mod=2: a 4-byte displacement is added.
  - Otherwise, when rm is not 4, the base register is rm.
- R7: Under 32-bit addressing, rm=4 (with mod not 3) brings in a SIB byte. In that byte, scale is bits 7:6, index is bits 5:3 and base is bits 2:0. An index of 4 means no index register. A base of 5 with mod=0 means no base register and a 4-byte displacement.
- R8: Under 16-bit addressing, mod=0 with rm=6 is a direct 2-byte displacement with no registers. mod=1 adds a 1-byte displacement and mod=2 adds a 2-byte displacement. rm values 0 to 7 select these base/index pairs, using register numbers 3, 5, 6 and 7:
  - rm 0: 3+6
  - rm 1: 3+7
  - rm 2: 5+6
  - rm 3: 5+7
  - rm 4: 6 as index only
  - rm 5: 7 as index only
  - rm 6: 5 as base only
  - rm 7: 3 as base only
- R9: Every displacement is sign-extended to 32 bits. Without a memory operand, the displacement, base, index and scale outputs are 0.
- R10: `in_imm_kind` selects the immediate size: 0 = none, 1 = one byte, 2 = two bytes, 3 = operand size (4 bytes if 32-bit, else 2). The immediate follows the displacement. It is sign-extended when `in_imm_signed` is 1 and zero-extended otherwise.
- R11: `out_len` is the sum of the prefix count, the opcode bytes, the ModRM byte, the SIB byte, the displacement bytes and the immediate bytes. A length of exactly `MAX_LEN` is legal.
- R12: `out_err` is 1, and `out_len` is 0, in either of two cases: the summed length exceeds `MAX_LEN`, or every byte of the window is a prefix. Bytes beyond the window read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Window offered |
| in_ready | output | 1 | Window can be taken |
| in_bytes | input | WIN_BYTES*8 | Byte window, byte 0 in bits 7:0 |
| in_dflt_op32 | input | 1 | Default operand size is 32-bit |
| in_dflt_ad32 | input | 1 | Default address size is 32-bit |
| in_has_modrm | input | 1 | Opcode is followed by ModRM |
| in_imm_kind | input | 2 | Immediate size code |
| in_imm_signed | input | 1 | Immediate is sign-extended |
| in_rep_ok | input | 1 | Opcode honours repeat prefixes |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Result taken |
| out_seg | output | 3 | Segment override code |
| out_lock | output | 1 | Lock prefix seen |
| out_rep | output | 2 | Repeat prefix bits |
| out_op32 | output | 1 | Effective operand size is 32-bit |
| out_ad32 | output | 1 | Effective address size is 32-bit |
| out_two_byte | output | 1 | Escape opcode present |
| out_mem | output | 1 | Memory operand present |
| out_reg | output | 3 | ModRM reg field |
| out_base_vld | output | 1 | Base register used |
| out_base | output | 3 | Base register number |
| out_idx_vld | output | 1 | Index register used |
| out_idx | output | 3 | Index register number |
| out_scale | output | 2 | Index scale exponent |
| out_disp | output | 32 | Sign-extended displacement |
| out_imm | output | 32 | Extended immediate |
| out_len | output | LEN_W | Instruction length in bytes |
| out_err | output | 1 | Window overrun or length over limit |

## Verification
The bench builds the block with its defaults, `WIN_BYTES` = 15 and `MAX_LEN` = 15, so the window is exactly as long as the longest legal instruction. With this setting, fifteen prefix bytes leave no opcode in reach. Fourteen size prefixes ahead of an opcode with ModRM push the sum to sixteen, and the read from past the window end comes back as zero. Eight segment prefixes before a seven-byte body land exactly on the limit, so both sides of the length boundary are covered.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;

  // segment override codes
  localparam logic [2:0] SEG_NONE = 3'd0;
  localparam logic [2:0] SEG_ES   = 3'd1;
  localparam logic [2:0] SEG_CS   = 3'd2;
  localparam logic [2:0] SEG_SS   = 3'd3;
  localparam logic [2:0] SEG_DS   = 3'd4;
  localparam logic [2:0] SEG_FS   = 3'd5;
  localparam logic [2:0] SEG_GS   = 3'd6;

  // register numbers used by the 16-bit pair table
  localparam logic [2:0] RN_B3 = 3'd3;
  localparam logic [2:0] RN_B5 = 3'd5;
  localparam logic [2:0] RN_X6 = 3'd6;
  localparam logic [2:0] RN_X7 = 3'd7;

  // immediate kind codes
  localparam logic [1:0] IMM_NONE = 2'd0;
  localparam logic [1:0] IMM_B1   = 2'd1;
  localparam logic [1:0] IMM_B2   = 2'd2;
  localparam logic [1:0] IMM_OPSZ = 2'd3;

  typedef struct packed {
    logic       mem;
    logic       has_sib;
    logic [2:0] disp_nb;
    logic [2:0] reg_f;
    logic       base_vld;
    logic [2:0] base;
    logic       idx_vld;
    logic [2:0] idx;
    logic [1:0] scale;
  } amode_t;

endpackage

// File: rtl/insn_prefix_scan.sv
module insn_prefix_scan
  import insn_dec_pkg::*;
#(
  parameter int WIN_BYTES = 15,
  localparam int CNT_W = $clog2(WIN_BYTES + 1)
) (
  input  logic [WIN_BYTES-1:0][7:0] win,
  output logic [CNT_W-1:0]          cnt,
  output logic [2:0]                seg,
  output logic                      lock,
  output logic [1:0]                rep,
  output logic                      tog_op,
  output logic                      tog_ad,
  output logic                      overrun
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  always_comb begin
    logic stop;
    stop    = 1'b0;
    cnt     = '0;
    seg     = SEG_NONE;
    lock    = 1'b0;
    rep     = 2'b00;
    tog_op  = 1'b0;
    tog_ad  = 1'b0;
    for (int i = 0; i < WIN_BYTES; i++) begin
      if (!stop) begin
        unique case (win[i])
          8'h26: seg = SEG_ES;
          8'h2E: seg = SEG_CS;
          8'h36: seg = SEG_SS;
          8'h3E: seg = SEG_DS;
          8'h64: seg = SEG_FS;
          8'h65: seg = SEG_GS;
          8'h66: tog_op = 1'b1;
          8'h67: tog_ad = 1'b1;
          8'hF0: lock = 1'b1;
          8'hF2: rep[0] = 1'b1;
          8'hF3: rep[1] = 1'b1;
          default: stop = 1'b1;
        endcase
        if (!stop) cnt = cnt + CNT_ONE;
      end
    end
    overrun = !stop;
  end

  // a stop inside the window leaves the count short of its size
  always_comb begin
    if (!overrun) assert_cnt_in_window_R12: assert (int'(cnt) < WIN_BYTES);
  end

endmodule

// File: rtl/insn_modrm_dec.sv
module insn_modrm_dec
  import insn_dec_pkg::*;
(
  input  logic       en,
  input  logic       ad32,
  input  logic [7:0] mrm,
  input  logic [7:0] sib,
  output amode_t     am
);

  logic [1:0] md;
  logic [2:0] rm;
  assign md = mrm[7:6];
  assign rm = mrm[2:0];

  always_comb begin
    am       = '0;
    am.reg_f = mrm[5:3];
    if (en && md != 2'd3) begin
      am.mem = 1'b1;
      if (ad32) begin
        unique case (md)
          2'd0: begin
            if (rm == 3'd4)      am.has_sib = 1'b1;
            else if (rm == 3'd5) am.disp_nb = 3'd4;
            else begin am.base_vld = 1'b1; am.base = rm; end
          end
          2'd1: begin
            am.disp_nb = 3'd1;
            if (rm == 3'd4) am.has_sib = 1'b1;
            else begin am.base_vld = 1'b1; am.base = rm; end
          end
          default: begin
            am.disp_nb = 3'd4;
            if (rm == 3'd4) am.has_sib = 1'b1;
            else begin am.base_vld = 1'b1; am.base = rm; end
          end
        endcase
        if (am.has_sib) begin
          am.scale = sib[7:6];
          if (sib[5:3] != 3'd4) begin
            am.idx_vld = 1'b1;
            am.idx     = sib[5:3];
          end
          if (sib[2:0] == 3'd5 && md == 2'd0) begin
            am.disp_nb = 3'd4;
          end else begin
            am.base_vld = 1'b1;
            am.base     = sib[2:0];
          end
        end
      end else begin
        unique case (md)
          2'd0:    am.disp_nb = (rm == 3'd6) ? 3'd2 : 3'd0;
          2'd1:    am.disp_nb = 3'd1;
          default: am.disp_nb = 3'd2;
        endcase
        if (!(md == 2'd0 && rm == 3'd6)) begin
          unique case (rm)
            3'd0: begin am.base_vld = 1'b1; am.base = RN_B3; am.idx_vld = 1'b1; am.idx = RN_X6; end
            3'd1: begin am.base_vld = 1'b1; am.base = RN_B3; am.idx_vld = 1'b1; am.idx = RN_X7; end
            3'd2: begin am.base_vld = 1'b1; am.base = RN_B5; am.idx_vld = 1'b1; am.idx = RN_X6; end
            3'd3: begin am.base_vld = 1'b1; am.base = RN_B5; am.idx_vld = 1'b1; am.idx = RN_X7; end
            3'd4: begin am.idx_vld = 1'b1; am.idx = RN_X6; end
            3'd5: begin am.idx_vld = 1'b1; am.idx = RN_X7; end
            3'd6: begin am.base_vld = 1'b1; am.base = RN_B5; end
            default: begin am.base_vld = 1'b1; am.base = RN_B3; end
          endcase
        end
      end
    end
  end

  always_comb begin
    if (am.has_sib) assert_sib_only_wide_R7: assert (ad32 && am.mem);
    if (!ad32) assert_no_wide_disp_narrow_R8: assert (am.disp_nb != 3'd4);
  end

endmodule

// File: rtl/insn_field_extract.sv
module insn_field_extract #(
  parameter int WIN_BYTES = 15,
  parameter int POS_W     = 5,
  localparam int IDX_W    = $clog2(WIN_BYTES)
) (
  input  logic [WIN_BYTES-1:0][7:0] win,
  input  logic [POS_W-1:0]          pos,
  input  logic [2:0]                nbytes,
  input  logic                      sgn,
  output logic [31:0]               val
);

  logic [3:0][7:0] b;

  for (genvar k = 0; k < 4; k++) begin : g_byte
    logic [POS_W:0] p;
    assign p = {1'b0, pos} + (POS_W + 1)'(k);
    assign b[k] = (int'(p) < WIN_BYTES) ? win[p[IDX_W-1:0]] : 8'h00;
  end

  always_comb begin
    unique case (nbytes)
      3'd1:    val = {{24{sgn & b[0][7]}}, b[0]};
      3'd2:    val = {{16{sgn & b[1][7]}}, b[1], b[0]};
      3'd4:    val = {b[3], b[2], b[1], b[0]};
      default: val = 32'h0;
    endcase
  end

endmodule

// File: rtl/insn_len_dec.sv
module insn_len_dec
  import insn_dec_pkg::*;
#(
  parameter int WIN_BYTES = 15,
  parameter int MAX_LEN   = 15,
  localparam int LEN_W    = $clog2(MAX_LEN + 1),
  localparam int CNT_W    = $clog2(WIN_BYTES + 1),
  localparam int IDX_W    = $clog2(WIN_BYTES),
  localparam int POS_W    = $clog2(WIN_BYTES + 13)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [WIN_BYTES*8-1:0] in_bytes,
  input  logic                   in_dflt_op32,
  input  logic                   in_dflt_ad32,
  input  logic                   in_has_modrm,
  input  logic [1:0]             in_imm_kind,
  input  logic                   in_imm_signed,
  input  logic                   in_rep_ok,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [2:0]             out_seg,
  output logic                   out_lock,
  output logic [1:0]             out_rep,
  output logic                   out_op32,
  output logic                   out_ad32,
  output logic                   out_two_byte,
  output logic                   out_mem,
  output logic [2:0]             out_reg,
  output logic                   out_base_vld,
  output logic [2:0]             out_base,
  output logic                   out_idx_vld,
  output logic [2:0]             out_idx,
  output logic [1:0]             out_scale,
  output logic [31:0]            out_disp,
  output logic [31:0]            out_imm,
  output logic [LEN_W-1:0]       out_len,
  output logic                   out_err
);

  logic [WIN_BYTES-1:0][7:0] win;
  assign win = in_bytes;

  function automatic logic [7:0] byte_at(input logic [POS_W-1:0] p);
    if (int'(p) < WIN_BYTES) return win[p[IDX_W-1:0]];
    return 8'h00;
  endfunction

  // ---------------- prefixes
  logic [CNT_W-1:0] pfx_cnt;
  logic [2:0]       seg;
  logic             lock, tog_op, tog_ad, overrun;
  logic [1:0]       rep_raw;

  insn_prefix_scan #(.WIN_BYTES(WIN_BYTES)) u_pfx (
    .win(win), .cnt(pfx_cnt), .seg(seg), .lock(lock), .rep(rep_raw),
    .tog_op(tog_op), .tog_ad(tog_ad), .overrun(overrun)
  );

  logic op32, ad32;
  assign op32 = in_dflt_op32 ^ tog_op;
  assign ad32 = in_dflt_ad32 ^ tog_ad;

  // ---------------- opcode and address form
  logic [POS_W-1:0] op_pos, mrm_pos, disp_pos, imm_pos, len_raw;
  logic             two_byte;
  logic [7:0]       mrm_b, sib_b;
  amode_t           am;

  assign op_pos   = POS_W'(pfx_cnt);
  assign two_byte = (byte_at(op_pos) == 8'h0F);
  assign mrm_pos  = op_pos + (two_byte ? POS_W'(2) : POS_W'(1));
  assign mrm_b    = in_has_modrm ? byte_at(mrm_pos) : 8'h00;
  assign sib_b    = byte_at(mrm_pos + POS_W'(1));

  insn_modrm_dec u_mrm (
    .en(in_has_modrm), .ad32(ad32), .mrm(mrm_b), .sib(sib_b), .am(am)
  );

  // ---------------- immediate size and positions
  logic [2:0] imm_nb;
  always_comb begin
    unique case (in_imm_kind)
      IMM_NONE: imm_nb = 3'd0;
      IMM_B1:   imm_nb = 3'd1;
      IMM_B2:   imm_nb = 3'd2;
      default:  imm_nb = op32 ? 3'd4 : 3'd2;
    endcase
  end

  assign disp_pos = mrm_pos + POS_W'(in_has_modrm) + POS_W'(am.has_sib);
  assign imm_pos  = disp_pos + POS_W'(am.disp_nb);
  assign len_raw  = imm_pos + POS_W'(imm_nb);

  logic [31:0] disp_v, imm_v;

  insn_field_extract #(.WIN_BYTES(WIN_BYTES), .POS_W(POS_W)) u_disp (
    .win(win), .pos(disp_pos), .nbytes(am.disp_nb), .sgn(1'b1), .val(disp_v)
  );

  insn_field_extract #(.WIN_BYTES(WIN_BYTES), .POS_W(POS_W)) u_imm (
    .win(win), .pos(imm_pos), .nbytes(imm_nb), .sgn(in_imm_signed), .val(imm_v)
  );

  logic err;
  assign err = overrun || (int'(len_raw) > MAX_LEN);

  // ---------------- output register stage
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_seg      <= '0;
      out_lock     <= 1'b0;
      out_rep      <= '0;
      out_op32     <= 1'b0;
      out_ad32     <= 1'b0;
      out_two_byte <= 1'b0;
      out_mem      <= 1'b0;
      out_reg      <= '0;
      out_base_vld <= 1'b0;
      out_base     <= '0;
      out_idx_vld  <= 1'b0;
      out_idx      <= '0;
      out_scale    <= '0;
      out_disp     <= '0;
      out_imm      <= '0;
      out_len      <= '0;
      out_err      <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_seg      <= seg;
        out_lock     <= lock;
        out_rep      <= in_rep_ok ? rep_raw : 2'b00;
        out_op32     <= op32;
        out_ad32     <= ad32;
        out_two_byte <= two_byte;
        out_mem      <= am.mem;
        out_reg      <= am.reg_f;
        out_base_vld <= am.base_vld;
        out_base     <= am.base;
        out_idx_vld  <= am.idx_vld;
        out_idx      <= am.idx;
        out_scale    <= am.scale;
        out_disp     <= disp_v;
        out_imm      <= imm_v;
        out_len      <= err ? '0 : LEN_W'(len_raw);
        out_err      <= err;
      end
    end
  end

  assert_hold_under_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_len) && $stable(out_disp)
                                && $stable(out_imm) && $stable(out_err));

  assert_rep_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_rep_ok |=> out_rep == 2'b00);

  assert_len_in_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_err |-> out_len != '0 && int'(out_len) <= MAX_LEN);

  assert_escape_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_two_byte && !out_err |-> int'(out_len) >= 2);

endmodule

// File: tb/insn_len_dec_bench.sv
module insn_len_dec_bench;

  localparam logic N = 1'b0;
  localparam logic Y = 1'b1;

  typedef struct packed {
    logic [2:0]  seg;
    logic        lock;
    logic [1:0]  rep;
    logic        op32, ad32, two, mem;
    logic [2:0]  rg;
    logic        bv;
    logic [2:0]  b;
    logic        iv;
    logic [2:0]  i;
    logic [1:0]  sc;
    logic [31:0] disp, imm;
    logic [3:0]  len;
    logic        err;
  } exp_t;

  typedef struct packed {
    logic [119:0] win;
    logic         d_op32, d_ad32, has_modrm;
    logic [1:0]   imm_kind;
    logic         imm_sgn, rep_ok;
    logic [3:0]   tag;
    exp_t         e;
  } vec_t;

  localparam int NV = 25;
  // windows are written high byte first; byte 0 is the rightmost pair
  localparam vec_t VT [NV] = '{
    // R5 R11: single-byte opcode
    '{120'h90, Y,Y,N,2'd0,N,N, 4'd11, '{3'd0,N,2'd0,Y,Y,N,N,3'd0,N,3'd0,N,3'd0,2'd0,32'h0,32'h0,4'd1,N}},
    // R6: mod 3 register form
    '{120'hC801, Y,Y,Y,2'd0,N,N, 4'd6, '{3'd0,N,2'd0,Y,Y,N,N,3'd1,N,3'd0,N,3'd0,2'd0,32'h0,32'h0,4'd2,N}},
    // R6: absolute disp32
    '{120'h12345678058B, Y,Y,Y,2'd0,N,N, 4'd6, '{3'd0,N,2'd0,Y,Y,N,Y,3'd0,N,3'd0,N,3'd0,2'd0,32'h12345678,32'h0,4'd6,N}},
    // R9: negative disp8
    '{120'hF0438B, Y,Y,Y,2'd0,N,N, 4'd9, '{3'd0,N,2'd0,Y,Y,N,Y,3'd0,Y,3'd3,N,3'd0,2'd0,32'hFFFFFFF0,32'h0,4'd3,N}},
    // R6: base plus disp32
    '{120'h00000100818B, Y,Y,Y,2'd0,N,N, 4'd6, '{3'd0,N,2'd0,Y,Y,N,Y,3'd0,Y,3'd1,N,3'd0,2'd0,32'h100,32'h0,4'd6,N}},
    // R7: SIB base+index*4
    '{120'h8B048B, Y,Y,Y,2'd0,N,N, 4'd7, '{3'd0,N,2'd0,Y,Y,N,Y,3'd0,Y,3'd3,Y,3'd1,2'd2,32'h0,32'h0,4'd3,N}},
    // R7: SIB with neither base nor index
    '{120'h1122334425048B, Y,Y,Y,2'd0,N,N, 4'd7, '{3'd0,N,2'd0,Y,Y,N,Y,3'd0,N,3'd0,N,3'd0,2'd0,32'h11223344,32'h0,4'd7,N}},
    // R7: SIB base 5 kept under mod 1
    '{120'h086D448B, Y,Y,Y,2'd0,N,N, 4'd7, '{3'd0,N,2'd0,Y,Y,N,Y,3'd0,Y,3'd5,Y,3'd5,2'd1,32'h8,32'h0,4'd4,N}},
    // R8: pair 3+6
    '{120'h008B, N,N,Y,2'd0,N,N, 4'd8, '{3'd0,N,2'd0,N,N,N,Y,3'd0,Y,3'd3,Y,3'd6,2'd0,32'h0,32'h0,4'd2,N}},
    // R8: direct disp16
    '{120'hF234068B, N,N,Y,2'd0,N,N, 4'd8, '{3'd0,N,2'd0,N,N,N,Y,3'd0,N,3'd0,N,3'd0,2'd0,32'hFFFFF234,32'h0,4'd4,N}},
    // R8: pair 5+6 disp8
    '{120'h7F528B, N,N,Y,2'd0,N,N, 4'd8, '{3'd0,N,2'd0,N,N,N,Y,3'd2,Y,3'd5,Y,3'd6,2'd0,32'h7F,32'h0,4'd3,N}},
    // R9: base 5 with negative disp16
    '{120'h8000868B, N,N,Y,2'd0,N,N, 4'd9, '{3'd0,N,2'd0,N,N,N,Y,3'd0,Y,3'd5,N,3'd0,2'd0,32'hFFFF8000,32'h0,4'd4,N}},
    // R4: address toggle
    '{120'h078B67, Y,Y,Y,2'd0,N,N, 4'd4, '{3'd0,N,2'd0,Y,N,N,Y,3'd0,Y,3'd3,N,3'd0,2'd0,32'h0,32'h0,4'd3,N}},
    // R4: doubled operand toggle, operand-size immediate
    '{120'h1234B86666, Y,Y,N,2'd3,N,N, 4'd4, '{3'd0,N,2'd0,N,Y,N,N,3'd0,N,3'd0,N,3'd0,2'd0,32'h0,32'h1234,4'd5,N}},
    // R10: signed imm8
    '{120'hFFC083, Y,Y,Y,2'd1,Y,N, 4'd10, '{3'd0,N,2'd0,Y,Y,N,N,3'd0,N,3'd0,N,3'd0,2'd0,32'h0,32'hFFFFFFFF,4'd3,N}},
    // R10: unsigned imm8
    '{120'h80C0C6, Y,Y,Y,2'd1,N,N, 4'd10, '{3'd0,N,2'd0,Y,Y,N,N,3'd0,N,3'd0,N,3'd0,2'd0,32'h0,32'h80,4'd3,N}},
    // R10: signed imm16
    '{120'hFFFEC2, Y,Y,N,2'd2,Y,N, 4'd10, '{3'd0,N,2'd0,Y,Y,N,N,3'd0,N,3'd0,N,3'd0,2'd0,32'h0,32'hFFFFFFFE,4'd3,N}},
    // R11: disp8 then imm32
    '{120'h12345678FC45C7, Y,Y,Y,2'd3,Y,N, 4'd11, '{3'd0,N,2'd0,Y,Y,N,Y,3'd0,Y,3'd5,N,3'd0,2'd0,32'hFFFFFFFC,32'h12345678,4'd7,N}},
    // R5 R2: lock, segment, escape
    '{120'h0BB10F2EF0, Y,Y,Y,2'd0,N,N, 4'd5, '{3'd2,Y,2'd0,Y,Y,Y,Y,3'd1,Y,3'd3,N,3'd0,2'd0,32'h0,32'h0,4'd5,N}},
    // R2: last segment wins
    '{120'hA5F36526, Y,Y,N,2'd0,N,Y, 4'd2, '{3'd6,N,2'd2,Y,Y,N,N,3'd0,N,3'd0,N,3'd0,2'd0,32'h0,32'h0,4'd4,N}},
    // R3: repeat cleared
    '{120'hA5F3F2, Y,Y,N,2'd0,N,N, 4'd3, '{3'd0,N,2'd0,Y,Y,N,N,3'd0,N,3'd0,N,3'd0,2'd0,32'h0,32'h0,4'd3,N}},
    // R3: both repeat bits
    '{120'hA6F2F3F2, Y,Y,N,2'd0,N,Y, 4'd3, '{3'd0,N,2'd3,Y,Y,N,N,3'd0,N,3'd0,N,3'd0,2'd0,32'h0,32'h0,4'd4,N}},
    // R12: length 16
    '{120'h8B6666666666666666666666666666, Y,Y,Y,2'd0,N,N, 4'd12, '{3'd0,N,2'd0,N,Y,N,Y,3'd0,Y,3'd0,N,3'd0,2'd0,32'h0,32'h0,4'd0,Y}},
    // R12: prefixes only
    '{120'hF0F0F0F0F0F0F0F0F0F0F0F0F0F0F0, Y,Y,N,2'd0,N,N, 4'd12, '{3'd0,Y,2'd0,Y,Y,N,N,3'd0,N,3'd0,N,3'd0,2'd0,32'h0,32'h0,4'd0,Y}},
    // R11: exactly 15
    '{120'h7F4433221105C73E3E3E3E3E3E3E3E, Y,Y,Y,2'd1,Y,N, 4'd11, '{3'd4,N,2'd0,Y,Y,N,Y,3'd0,N,3'd0,N,3'd0,2'd0,32'h44332211,32'h7F,4'd15,N}}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, in_ready;
  logic [119:0] in_bytes = '0;
  logic         in_dflt_op32 = 1'b1, in_dflt_ad32 = 1'b1, in_has_modrm = 1'b0;
  logic [1:0]   in_imm_kind = 2'd0;
  logic         in_imm_signed = 1'b0, in_rep_ok = 1'b0;
  logic         out_valid, out_ready = 1'b1;
  logic [2:0]   out_seg, out_reg, out_base, out_idx;
  logic         out_lock, out_op32, out_ad32, out_two_byte, out_mem;
  logic         out_base_vld, out_idx_vld, out_err;
  logic [1:0]   out_rep, out_scale;
  logic [31:0]  out_disp, out_imm;
  logic [3:0]   out_len;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  insn_len_dec u_insn_len_dec (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bytes(in_bytes), .in_dflt_op32(in_dflt_op32), .in_dflt_ad32(in_dflt_ad32),
    .in_has_modrm(in_has_modrm), .in_imm_kind(in_imm_kind),
    .in_imm_signed(in_imm_signed), .in_rep_ok(in_rep_ok),
    .out_valid(out_valid), .out_ready(out_ready), .out_seg(out_seg),
    .out_lock(out_lock), .out_rep(out_rep), .out_op32(out_op32),
    .out_ad32(out_ad32), .out_two_byte(out_two_byte), .out_mem(out_mem),
    .out_reg(out_reg), .out_base_vld(out_base_vld), .out_base(out_base),
    .out_idx_vld(out_idx_vld), .out_idx(out_idx), .out_scale(out_scale),
    .out_disp(out_disp), .out_imm(out_imm), .out_len(out_len), .out_err(out_err)
  );

  function automatic exp_t observed();
    return '{out_seg, out_lock, out_rep, out_op32, out_ad32, out_two_byte, out_mem,
             out_reg, out_base_vld, out_base, out_idx_vld, out_idx, out_scale,
             out_disp, out_imm, out_len, out_err};
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_bytes      = v.win;
    in_dflt_op32  = v.d_op32;
    in_dflt_ad32  = v.d_ad32;
    in_has_modrm  = v.has_modrm;
    in_imm_kind   = v.imm_kind;
    in_imm_signed = v.imm_sgn;
    in_rep_ok     = v.rep_ok;
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset out_valid", 128'(out_valid), 128'(0));
    check("R1 reset in_ready", 128'(in_ready), 128'(1));
    rst_n = 1'b1;
    @(negedge clk);

    // table walk
    for (int k = 0; k < NV; k++) begin
      drive(VT[k]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R1 vec %0d valid", k), 128'(out_valid), 128'(1));
      check($sformatf("vec %0d (R%0d)", k, VT[k].tag), 128'(observed()), 128'(VT[k].e));
    end
    @(negedge clk);

    // R1: back-pressure holds the result and blocks intake
    out_ready = 1'b0;
    drive(VT[2]);
    in_valid = 1'b1;
    @(negedge clk);
    drive(VT[0]);
    repeat (3) @(negedge clk);
    check("R1 stall valid", 128'(out_valid), 128'(1));
    check("R1 stall ready low", 128'(in_ready), 128'(0));
    check("R1 stall held", 128'(observed()), 128'(VT[2].e));
    out_ready = 1'b1;
    @(negedge clk);
    check("R1 drained then refilled", 128'(observed()), 128'(VT[0].e));
    check("R1 refill valid", 128'(out_valid), 128'(1));
    in_valid = 1'b0;
    @(negedge clk);
    check("R1 empty after drain", 128'(out_valid), 128'(0));

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule